// File: doc/BRIEF.md
# Floating-point exponent extraction unit

This unit takes one single-precision floating-point operand and returns the integer part of the base-2 logarithm of its magnitude, floor(log2(|x|)). The result is itself a single-precision value. For a normal operand that is the biased exponent field minus 127. For a subnormal operand the unit finds the most significant set fraction bit and uses it to get the true exponent. Zero, infinity and NaN operands produce fixed special results. An invalid flag and a subnormal flag come out next to the result as plain signals. There is no trapping.

A control input, `in_flush_sub`, makes the unit treat subnormal operands as zero. The unit has one register stage. An operand presented with `in_valid` high appears with `out_valid` one clock later. The outputs hold their value until the next valid operand arrives.

Top module: `fexp_extract`

## Requirements
- R1: For an operand with exponent field E in 1..254, the result is the single-precision encoding of the integer E-127, exact and with no rounding. Negative integers set bit 31. Both flags are low. The operand sign and fraction bits have no effect.
- R2: An operand with exponent field 127 gives integer zero, which is returned as +0.0 (32'h00000000).
- R3: For a subnormal operand (exponent field 0, fraction nonzero) with `in_flush_sub` low, let k be the position of the highest set fraction bit (22..0). The result is the encoding of k-149, so bit 22 gives -127 and bit 0 gives -149. `out_denorm` is high and `out_invalid` is low.
- R4: An operand with exponent field 0 and fraction 0 gives -INF (32'hFF800000) for either sign. Both flags are low.
- R5: With `in_flush_sub` high, a subnormal operand gives -INF (32'hFF800000) and both flags are low. `in_flush_sub` has no effect on any other class of operand.
- R6: An operand with exponent field 255 and fraction 0 gives +INF (32'h7F800000) for either sign. Both flags are low.
- R7: An operand with exponent field 255 and a nonzero fraction (NaN) gives the operand with fraction bit 22 forced to 1. The sign and fraction bits 21..0 are kept. `out_invalid` is high exactly when fraction bit 22 of the operand was 0 (signaling NaN). `out_denorm` is low.
- R8: `out_valid` equals `in_valid` from the previous clock. When `in_valid` is low, `out_value`, `out_invalid` and `out_denorm` keep their previous values.
- R9: While `rst` is high at a clock edge, `out_valid`, `out_value`, `out_invalid` and `out_denorm` all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand is present this cycle |
| in_operand | input | 32 | Single-precision operand |
| in_flush_sub | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Result register holds a new result |
| out_value | output | 32 | floor(log2(\|x\|)) as a single-precision value |
| out_invalid | output | 1 | Operand was a signaling NaN |
| out_denorm | output | 1 | Operand was a subnormal that was not flushed |

## Verification
Every special class is applied with both signs, and every class is applied with both settings of the flush control. This separates the flush path from the true-zero path and shows that the flush control has no effect on normals. Each of the 23 subnormal leading-one positions is applied with random lower bits. This catches a leading-one counter that is off by one or that is disturbed by bits below the leading one. A random sweep of normal operands, together with the exponent fields 1, 126, 127, 128 and 254, exercises every magnitude and both signs of the integer-to-float step. Idle cycles with changing operand inputs show that the result register holds its value.

// File: rtl/fexp_pkg.sv
package fexp_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int LZC_W   = $clog2(FRAC_W + 1);
    localparam int INT_W   = EXP_W + 2;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  bexp;
        logic [FRAC_W-1:0] frac;
    } sp_t;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } opclass_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              invalid;
        logic              denorm;
    } outcome_t;

    // A flushed subnormal is classed as zero.
    function automatic opclass_e classify(input sp_t x, input logic flush);
        if (x.bexp == {EXP_W{1'b1}})
            return (x.frac == '0) ? CLS_INF : CLS_NAN;
        if (x.bexp == '0)
            return ((x.frac == '0) || flush) ? CLS_ZERO : CLS_SUB;
        return CLS_NORM;
    endfunction

    function automatic logic [WORD_W-1:0] infinity(input logic neg);
        return {neg, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] quieten(input sp_t x);
        return {x.sign, x.bexp, 1'b1, x.frac[FRAC_W-2:0]};
    endfunction

endpackage

// File: rtl/fexp_lzc.sv
module fexp_lzc #(
    parameter int WIDTH = 23,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CNT_W-1:0] cnt
);
    // hit[i]: bit i is set and no bit above it is set
    logic [WIDTH-1:0] above;
    logic [WIDTH-1:0] hit;

    assign above[WIDTH-1] = 1'b0;
    genvar g;
    generate
        for (g = WIDTH - 2; g >= 0; g--) begin : g_chain
            assign above[g] = above[g+1] | vec[g+1];
        end
        for (g = 0; g < WIDTH; g++) begin : g_hit
            assign hit[g] = vec[g] & ~above[g];
        end
    endgenerate

    always_comb begin
        cnt = CNT_W'(WIDTH);
        for (int i = 0; i < WIDTH; i++) begin
            if (hit[i]) cnt = CNT_W'(WIDTH - 1 - i);
        end
    end
endmodule

// File: rtl/fexp_int2fp.sv
module fexp_int2fp #(
    parameter int INT_W  = 10,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
    localparam int IDX_W = $clog2(INT_W)
) (
    input  logic signed [INT_W-1:0]        ival,
    output logic [EXP_W+FRAC_W:0]          fp
);
    logic [INT_W-1:0]  mag;
    logic [IDX_W-1:0]  msb;
    logic [FRAC_W-1:0] mant;

    always_comb begin
        mag = ival[INT_W-1] ? INT_W'(-ival) : INT_W'(ival);
        msb = '0;
        for (int i = 0; i < INT_W; i++) begin
            if (mag[i]) msb = IDX_W'(i);
        end
        // place the leading one just above the fraction field and drop it
        mant = FRAC_W'({mag, {FRAC_W{1'b0}}} >> msb);
        if (mag == '0)
            fp = '0;
        else
            fp = {ival[INT_W-1], EXP_W'(BIAS + int'(msb)), mant};
    end
endmodule

// File: rtl/fexp_core.sv
module fexp_core
    import fexp_pkg::*;
(
    input  sp_t      operand,
    input  logic     flush,
    output outcome_t outcome
);
    localparam logic signed [INT_W-1:0] BIAS_I = INT_W'(BIAS);

    opclass_e                 cls;
    logic [LZC_W-1:0]         lead_zeros;
    logic signed [INT_W-1:0]  unbiased;
    logic [WORD_W-1:0]        converted;

    assign cls = classify(operand, flush);

    fexp_lzc #(.WIDTH(FRAC_W), .CNT_W(LZC_W)) u_lzc (
        .vec (operand.frac),
        .cnt (lead_zeros)
    );

    always_comb begin
        if (cls == CLS_SUB)
            unbiased = -BIAS_I - INT_W'(lead_zeros);
        else
            unbiased = INT_W'({1'b0, operand.bexp}) - BIAS_I;
    end

    fexp_int2fp #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cvt (
        .ival (unbiased),
        .fp   (converted)
    );

    always_comb begin
        outcome = '0;
        case (cls)
            CLS_ZERO: outcome.value = infinity(1'b1);
            CLS_INF:  outcome.value = infinity(1'b0);
            CLS_NAN: begin
                outcome.value   = quieten(operand);
                outcome.invalid = ~operand.frac[FRAC_W-1];
            end
            CLS_SUB: begin
                outcome.value  = converted;
                outcome.denorm = 1'b1;
            end
            CLS_NORM: outcome.value = converted;
            default:  outcome = '0;
        endcase
    end
endmodule

// File: rtl/fexp_extract.sv
module fexp_extract
    import fexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_operand,
    input  logic              in_flush_sub,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_value,
    output logic              out_invalid,
    output logic              out_denorm
);
    outcome_t next_q;
    outcome_t held_q;

    fexp_core u_core (
        .operand (sp_t'(in_operand)),
        .flush   (in_flush_sub),
        .outcome (next_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held_q    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) held_q <= next_q;
        end
    end

    assign out_value   = held_q.value;
    assign out_invalid = held_q.invalid;
    assign out_denorm  = held_q.denorm;
endmodule

// File: rtl/fexp_extract_chk.sv
module fexp_extract_chk
    import fexp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_operand,
    input logic              in_flush_sub,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_value,
    input logic              out_invalid,
    input logic              out_denorm
);
    logic is_inf, is_nan, is_zero, is_sub, is_norm;
    assign is_inf  = (in_operand[30:23] == 8'hFF) && (in_operand[22:0] == '0);
    assign is_nan  = (in_operand[30:23] == 8'hFF) && (in_operand[22:0] != '0);
    assign is_zero = (in_operand[30:0] == '0);
    assign is_sub  = (in_operand[30:23] == 8'h00) && (in_operand[22:0] != '0);
    assign is_norm = (in_operand[30:23] != 8'h00) && (in_operand[30:23] != 8'hFF);

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_follows_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_value) && $stable(out_invalid) && $stable(out_denorm)));
    p_inf_plus_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_inf) |=> (out_value == 32'h7F800000 && !out_invalid && !out_denorm));
    p_zero_minus_inf_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_zero) |=> (out_value == 32'hFF800000 && !out_invalid && !out_denorm));
    p_flush_sub_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_sub && in_flush_sub) |=> (out_value == 32'hFF800000 && !out_denorm));
    p_sub_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_sub && !in_flush_sub) |=> (out_denorm && !out_invalid && out_value[31]));
    p_nan_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_nan) |=> (out_value[30:22] == 9'h1FF && out_invalid == !$past(in_operand[22])));
    p_norm_noflag_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_norm) |=> (!out_invalid && !out_denorm));
    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_invalid, out_denorm}));
endmodule

bind fexp_extract fexp_extract_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_operand   (in_operand),
    .in_flush_sub (in_flush_sub),
    .out_valid    (out_valid),
    .out_value    (out_value),
    .out_invalid  (out_invalid),
    .out_denorm   (out_denorm)
);

// File: tb/fexp_extract_test.sv
`timescale 1ns/1ps
module fexp_extract_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        in_flush_sub = 1'b0;
    logic        out_valid;
    logic [31:0] out_value;
    logic        out_invalid;
    logic        out_denorm;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;

    always #4 clk = ~clk;

    fexp_extract uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_flush_sub(in_flush_sub), .out_valid(out_valid), .out_value(out_value),
        .out_invalid(out_invalid), .out_denorm(out_denorm)
    );

    // integer -> single via the double-precision bit pattern
    function automatic logic [31:0] int_to_single(input int e);
        logic [63:0] d;
        logic [10:0] de;
        if (e == 0) return 32'h0;
        d  = $realtobits(real'(e));
        de = d[62:52] - 11'd896;
        return {d[63], de[7:0], d[51:29]};
    endfunction

    task automatic reference(input logic [31:0] x, input bit daz,
                             output logic [31:0] v, output bit inv, output bit den,
                             output string tag);
        int ex = int'(x[30:23]);
        logic [22:0] fr = x[22:0];
        int top = -1;
        inv = 0; den = 0;
        if (ex == 255 && fr != 0) begin
            v = x | 32'h0040_0000; inv = !fr[22]; tag = "R7";
        end else if (ex == 255) begin
            v = 32'h7F80_0000; tag = "R6";
        end else if (ex == 0 && fr == 0) begin
            v = 32'hFF80_0000; tag = "R4";
        end else if (ex == 0 && daz) begin
            v = 32'hFF80_0000; tag = "R5";
        end else if (ex == 0) begin
            for (int b = 0; b < 23; b++) if (fr[b]) top = b;
            v = int_to_single(top - 149); den = 1; tag = "R3";
        end else begin
            v = int_to_single(ex - 127);
            tag = (ex == 127) ? "R2" : "R1";
        end
    endtask

    // cycle model
    logic [31:0] m_value = '0;
    bit          m_valid = 0, m_inv = 0, m_den = 0;
    string       m_tag = "R9";

    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 0; m_value <= '0; m_inv <= 0; m_den <= 0; m_tag <= "R9";
        end else begin
            m_valid <= in_valid;
            if (in_valid) begin
                logic [31:0] v; bit i, d; string t;
                reference(in_operand, in_flush_sub, v, i, d, t);
                m_value <= v; m_inv <= i; m_den <= d; m_tag <= t;
            end else begin
                m_tag <= "R8";
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (out_valid !== m_valid) begin
                errors++;
                $display("FAIL R8 out_valid actual %0b expected %0b", out_valid, m_valid);
            end
            checks++;
            if (out_value !== m_value) begin
                errors++;
                $display("FAIL %s value actual %h expected %h", m_tag, out_value, m_value);
            end
            checks++;
            if (out_invalid !== m_inv || out_denorm !== m_den) begin
                errors++;
                $display("FAIL %s flags inv/den actual %0b%0b expected %0b%0b",
                         m_tag, out_invalid, out_denorm, m_inv, m_den);
            end
        end
    end

    task automatic send(input logic [31:0] x, input bit daz);
        @(negedge clk);
        in_valid = 1; in_operand = x; in_flush_sub = daz;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 0; in_operand = $urandom; in_flush_sub = $urandom;
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R9 reset state
        if (out_valid !== 0 || out_value !== 0 || out_invalid !== 0 || out_denorm !== 0) begin
            errors++;
            $display("FAIL R9 reset actual %0b %h %0b %0b expected 0 0 0 0",
                     out_valid, out_value, out_invalid, out_denorm);
        end
        rst = 0; mon_on = 1;

        for (int daz = 0; daz < 2; daz++) begin
            send(32'h0000_0000, daz); send(32'h8000_0000, daz);     // R4
            send(32'h7F80_0000, daz); send(32'hFF80_0000, daz);     // R6
            send(32'h7FC0_1234, daz); send(32'hFF80_0001, daz);     // R7
            send(32'h7FA5_5555, daz); send(32'hFFFF_FFFF, daz);     // R7
            send(32'h3F80_0000, daz); send(32'hBFFF_FFFF, daz);     // R2
            send(32'h0080_0000, daz); send(32'h7F7F_FFFF, daz);     // R1 ends
            send(32'h3F00_0000, daz); send(32'h4000_0000, daz);     // R1 -1,+1
            idle(2);                                                 // R8 hold
        end

        for (int daz = 0; daz < 2; daz++) begin
            for (int b = 0; b < 23; b++) begin
                logic [22:0] low = 23'($urandom) & 23'((1 << b) - 1);
                send({1'($urandom), 8'h00, 23'(1 << b) | low}, daz); // R3 / R5
            end
            idle(1);
        end

        for (int n = 0; n < 3000; n++) begin
            logic [7:0] e = 8'(1 + ($urandom % 254));
            send({1'($urandom), e, 23'($urandom)}, 1'($urandom));    // R1 / R5
            if ($urandom % 7 == 0) idle(1 + $urandom % 3);           // R8
        end

        idle(3);
        rst = 1;
        @(negedge clk);
        mon_on = 0;
        checks++;  // R9 reset after activity
        if (out_valid !== 0 || out_value !== 0 || out_invalid !== 0 || out_denorm !== 0) begin
            errors++;
            $display("FAIL R9 re-reset actual %0b %h expected 0 0", out_valid, out_value);
        end
        finish_run();
    end
endmodule